// File: doc/BRIEF.md
# Ethernet receive address filter

This block decides whether an incoming Ethernet frame is kept, based on its 48-bit destination address. The receive path hands it the six address bytes one per cycle, in wire order. The first byte is marked with a start flag. One cycle after the sixth byte the block returns a one-cycle result: an accept bit and three class flags (multicast, broadcast, and "kept only because every frame is passed").

A small write-only register port holds the mode bits, the station address and a 64-bit multicast hash table. The hash index comes from a CRC-32 that the block computes over the address bytes as they arrive, so no extra cycles are needed once the last byte is in. The modes are promiscuous, pass-every-frame, pass-every-multicast, hash-checked multicast, hash-checked unicast, inverted unicast test and broadcast disable. Each mode bit is independent of the others, so they can be combined.

Top module: `rx_addr_filter`

## Requirements
- R1: A byte with `da_valid` and `da_sof` high is address byte 0, and each later `da_valid` byte fills the next position. Idle cycles between bytes are allowed. A new `da_sof` restarts capture. Bytes that arrive with no open frame are ignored: after reset, or after the sixth byte, until the next `da_sof`. `res_valid` is high for exactly the one cycle after the sixth byte.
- R2: A write with `cfg_we` high stores `cfg_wdata` according to `cfg_sel`:
  - 0 is the mode word.
  - 1 is station address byte 5 in bits 15:8 and byte 4 in bits 7:0.
  - 2 is station address bytes 3, 2, 1 and 0 in bits 31:24, 23:16, 15:8 and 7:0.
  - 3 is hash table bits 63:32.
  - 4 is hash table bits 31:0.

  The mode word bits are: 11 broadcast disable, 13 multicast hash check, 15 unicast hash check, 16 pass every frame, 17 invert unicast test, 18 promiscuous, 19 pass every multicast.
- R3: The hash index is bits 31:26 of a CRC-32 (polynomial 0x04C11DB7, initial value all ones, no final inversion) run over bytes 0 to 5, each byte least significant bit first. The shift register moves toward its most significant bit. The indexed bit of the 64-bit table is the hash hit.
- R4: A frame is a group frame when bit 0 of byte 0 is 1, and broadcast when all 48 bits are 1. `res_mcast` marks group frames that are not broadcast, and `res_bcast` marks broadcast frames. The two flags are never high together.
- R5: With no mode bits set, a unicast frame is accepted exactly when its address equals the station address.
- R6: Invert unicast (bit 17) inverts the unicast test, including its hash form. It has no effect on group frames.
- R7: With unicast hash check (bit 15) set, the unicast test uses the hash hit instead of the exact compare.
- R8: A broadcast frame passes the filter unless broadcast disable (bit 11) is set. Pass-every-multicast does not override broadcast disable.
- R9: A non-broadcast group frame passes when pass-every-multicast (bit 19) is set, or when multicast hash check (bit 13) is set and the hash hit is 1.
- R10: Promiscuous (bit 18) accepts every frame with `res_filt_fail` low. The class flags still follow R4.
- R11: Pass every frame (bit 16) accepts every frame. It raises `res_filt_fail` when the filter alone would reject the frame and promiscuous is off.
- R12: `res_accept`, `res_mcast`, `res_bcast` and `res_filt_fail` are 0 outside the `res_valid` cycle and on rejected frames. After reset all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 3 | Register select |
| cfg_wdata | input | 32 | Register write data |
| da_valid | input | 1 | Address byte valid |
| da_sof | input | 1 | Marks address byte 0 |
| da_byte | input | 8 | Address byte |
| res_valid | output | 1 | Result pulse |
| res_accept | output | 1 | Frame accepted |
| res_mcast | output | 1 | Non-broadcast group frame (accepted frames only) |
| res_bcast | output | 1 | Broadcast frame (accepted frames only) |
| res_filt_fail | output | 1 | Accepted only by pass-every-frame |

## Verification
The bench builds the block with its defaults: a six-byte address, a six-bit hash index and the unicast hash variant enabled. These defaults make the whole 64-entry table reachable, so the bench can find addresses whose index falls in either 32-bit half and check the half mapping. They also bring the unicast hash path and its interaction with the inverted test within reach. A vector table covers each mode alone and in conflicting pairs. Directed runs then cover gaps between bytes, stray bytes, capture restart and reset in mid-frame.

// File: rtl/rx_addr_filter_pkg.sv
package rx_addr_filter_pkg;

   // Mode word bit positions (software decodes these)
   localparam int MB_BCAST_OFF = 11;
   localparam int MB_HASH_MC   = 13;
   localparam int MB_HASH_UC   = 15;
   localparam int MB_PASS_ALL  = 16;
   localparam int MB_INVERT    = 17;
   localparam int MB_PROMISC   = 18;
   localparam int MB_ALL_MC    = 19;

   localparam int          CFG_W     = 32;
   localparam int          SEL_W     = 3;
   localparam logic [31:0] CRC_POLY  = 32'h04C11DB7;

   typedef enum logic [SEL_W-1:0] {
      SEL_MODE    = 3'd0,
      SEL_STA_HI  = 3'd1,
      SEL_STA_LO  = 3'd2,
      SEL_HASH_HI = 3'd3,
      SEL_HASH_LO = 3'd4
   } cfg_sel_e;

   typedef struct packed {
      logic all_mc;
      logic promisc;
      logic invert;
      logic pass_all;
      logic hash_uc;
      logic hash_mc;
      logic bcast_off;
   } mode_t;

   // One address byte into the running CRC, least significant bit first
   function automatic logic [31:0] crc_byte_step(input logic [31:0] c_in,
                                                 input logic [7:0]  b);
      logic [31:0] c;
      logic        fb;
      c = c_in;
      for (int i = 0; i < 8; i++) begin
         fb = c[31] ^ b[i];
         c  = {c[30:0], 1'b0};
         if (fb) c = c ^ CRC_POLY;
      end
      return c;
   endfunction

endpackage

// File: rtl/rx_af_cfg_regs.sv
module rx_af_cfg_regs
   import rx_addr_filter_pkg::*;
#(
   parameter  int ADDR_BYTES = 6,
   parameter  int HASH_BITS  = 6,
   localparam int ADDR_W     = 8 * ADDR_BYTES,
   localparam int TABLE_BITS = 1 << HASH_BITS
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  we,
   input  logic [SEL_W-1:0]      sel,
   input  logic [CFG_W-1:0]      wdata,
   output mode_t                 mode_q,
   output logic [ADDR_W-1:0]     station_q,
   output logic [TABLE_BITS-1:0] table_q
);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mode_q    <= '0;
         station_q <= '0;
         table_q   <= '0;
      end else if (we) begin
         unique case (sel)
            SEL_MODE: begin
               mode_q.bcast_off <= wdata[MB_BCAST_OFF];
               mode_q.hash_mc   <= wdata[MB_HASH_MC];
               mode_q.hash_uc   <= wdata[MB_HASH_UC];
               mode_q.pass_all  <= wdata[MB_PASS_ALL];
               mode_q.invert    <= wdata[MB_INVERT];
               mode_q.promisc   <= wdata[MB_PROMISC];
               mode_q.all_mc    <= wdata[MB_ALL_MC];
            end
            SEL_STA_HI:  station_q[ADDR_W-1:CFG_W]  <= wdata[ADDR_W-CFG_W-1:0];
            SEL_STA_LO:  station_q[CFG_W-1:0]       <= wdata;
            SEL_HASH_HI: table_q[TABLE_BITS-1:CFG_W] <= wdata;
            SEL_HASH_LO: table_q[CFG_W-1:0]         <= wdata;
            default: ;
         endcase
      end
   end

endmodule

// File: rtl/rx_af_collect.sv
module rx_af_collect
   import rx_addr_filter_pkg::*;
#(
   parameter  int ADDR_BYTES = 6,
   parameter  int HASH_BITS  = 6,
   localparam int ADDR_W     = 8 * ADDR_BYTES,
   localparam int CNT_W      = $clog2(ADDR_BYTES + 1)
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 da_valid,
   input  logic                 da_sof,
   input  logic [7:0]           da_byte,
   output logic                 last,
   output logic [ADDR_W-1:0]    addr_nx,
   output logic [HASH_BITS-1:0] hash_idx
);

   localparam logic [CNT_W-1:0] IDLE_CNT = CNT_W'(ADDR_BYTES);
   localparam logic [CNT_W-1:0] LAST_POS = CNT_W'(ADDR_BYTES - 1);

   logic [CNT_W-1:0]  cnt_q;
   logic [CNT_W-1:0]  pos;
   logic              take;
   logic [ADDR_W-1:0] addr_q;
   logic [31:0]       crc_q;
   logic [31:0]       crc_base;
   logic [31:0]       crc_nx;

   assign pos      = da_sof ? '0 : cnt_q;
   assign take     = da_valid && (da_sof || (cnt_q < IDLE_CNT));
   assign last     = take && (pos == LAST_POS);
   assign crc_base = (pos == '0) ? '1 : crc_q;
   assign crc_nx   = crc_byte_step(crc_base, da_byte);
   assign hash_idx = crc_nx[31 -: HASH_BITS];

   for (genvar k = 0; k < ADDR_BYTES; k++) begin : g_lane
      assign addr_nx[8*k +: 8] = (take && (pos == CNT_W'(k))) ? da_byte
                                                              : addr_q[8*k +: 8];
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q  <= IDLE_CNT;
         addr_q <= '0;
         crc_q  <= '1;
      end else if (take) begin
         cnt_q  <= pos + 1'b1;
         addr_q <= addr_nx;
         crc_q  <= crc_nx;
      end
   end

endmodule

// File: rtl/rx_af_decide.sv
module rx_af_decide
   import rx_addr_filter_pkg::*;
#(
   parameter  int ADDR_BYTES = 6,
   parameter  int HASH_BITS  = 6,
   parameter  bit UC_HASH_EN = 1'b1,
   localparam int ADDR_W     = 8 * ADDR_BYTES,
   localparam int TABLE_BITS = 1 << HASH_BITS
) (
   input  logic [ADDR_W-1:0]     addr,
   input  logic [ADDR_W-1:0]     station,
   input  logic [TABLE_BITS-1:0] table_bits,
   input  logic [HASH_BITS-1:0]  hash_idx,
   input  mode_t                 mode,
   output logic                  accept,
   output logic                  grp_flag,
   output logic                  bc_flag,
   output logic                  fail_flag
);

   logic group, bcast, exact, hit, uc_raw, uc_ok, bc_ok, mc_ok, filt_ok;

   assign group = addr[0];
   assign bcast = &addr;
   assign exact = (addr == station);
   assign hit   = table_bits[hash_idx];

   if (UC_HASH_EN) begin : g_uc_hash
      assign uc_raw = mode.hash_uc ? hit : exact;
   end else begin : g_uc_exact
      assign uc_raw = exact;
   end

   assign uc_ok   = !group && (uc_raw ^ mode.invert);
   assign bc_ok   = bcast && !mode.bcast_off;
   assign mc_ok   = group && !bcast && (mode.all_mc || (mode.hash_mc && hit));
   assign filt_ok = uc_ok || bc_ok || mc_ok;

   assign accept    = mode.promisc || mode.pass_all || filt_ok;
   assign grp_flag  = group && !bcast;
   assign bc_flag   = bcast;
   assign fail_flag = mode.pass_all && !mode.promisc && !filt_ok;

endmodule

// File: rtl/rx_addr_filter.sv
module rx_addr_filter
   import rx_addr_filter_pkg::*;
#(
   parameter int ADDR_BYTES = 6,
   parameter int HASH_BITS  = 6,
   parameter bit UC_HASH_EN = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cfg_we,
   input  logic [2:0]       cfg_sel,
   input  logic [31:0]      cfg_wdata,
   input  logic             da_valid,
   input  logic             da_sof,
   input  logic [7:0]       da_byte,
   output logic             res_valid,
   output logic             res_accept,
   output logic             res_mcast,
   output logic             res_bcast,
   output logic             res_filt_fail
);

   localparam int ADDR_W     = 8 * ADDR_BYTES;
   localparam int TABLE_BITS = 1 << HASH_BITS;

   if (ADDR_BYTES != 6) begin : g_bad_addr
      $error("rx_addr_filter: register map needs a six-byte address");
   end
   if (TABLE_BITS != 2 * CFG_W) begin : g_bad_hash
      $error("rx_addr_filter: hash table must span two register words");
   end

   mode_t                 mode_q;
   logic [ADDR_W-1:0]     station_q;
   logic [TABLE_BITS-1:0] table_q;
   logic                  last;
   logic [ADDR_W-1:0]     addr_nx;
   logic [HASH_BITS-1:0]  hash_idx;
   logic                  accept, grp_flag, bc_flag, fail_flag;

   rx_af_cfg_regs #(.ADDR_BYTES(ADDR_BYTES), .HASH_BITS(HASH_BITS)) u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .we        (cfg_we),
      .sel       (cfg_sel),
      .wdata     (cfg_wdata),
      .mode_q    (mode_q),
      .station_q (station_q),
      .table_q   (table_q)
   );

   rx_af_collect #(.ADDR_BYTES(ADDR_BYTES), .HASH_BITS(HASH_BITS)) u_collect (
      .clk      (clk),
      .rst_n    (rst_n),
      .da_valid (da_valid),
      .da_sof   (da_sof),
      .da_byte  (da_byte),
      .last     (last),
      .addr_nx  (addr_nx),
      .hash_idx (hash_idx)
   );

   rx_af_decide #(.ADDR_BYTES(ADDR_BYTES), .HASH_BITS(HASH_BITS),
                  .UC_HASH_EN(UC_HASH_EN)) u_decide (
      .addr       (addr_nx),
      .station    (station_q),
      .table_bits (table_q),
      .hash_idx   (hash_idx),
      .mode       (mode_q),
      .accept     (accept),
      .grp_flag   (grp_flag),
      .bc_flag    (bc_flag),
      .fail_flag  (fail_flag)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         res_valid     <= 1'b0;
         res_accept    <= 1'b0;
         res_mcast     <= 1'b0;
         res_bcast     <= 1'b0;
         res_filt_fail <= 1'b0;
      end else begin
         res_valid     <= last;
         res_accept    <= last && accept;
         res_mcast     <= last && accept && grp_flag;
         res_bcast     <= last && accept && bc_flag;
         res_filt_fail <= last && accept && fail_flag;
      end
   end

endmodule

// File: rtl/rx_addr_filter_chk.sv
module rx_addr_filter_chk
   import rx_addr_filter_pkg::*;
(
   input logic  clk,
   input logic  rst_n,
   input logic  da_valid,
   input logic  res_valid,
   input logic  res_accept,
   input logic  res_mcast,
   input logic  res_bcast,
   input logic  res_filt_fail,
   input mode_t mode_q
);

   p_res_after_byte_r1: assert property (@(posedge clk) disable iff (!rst_n)
      res_valid |-> $past(da_valid));

   p_res_single_r1: assert property (@(posedge clk) disable iff (!rst_n)
      res_valid |=> !res_valid);

   p_class_excl_r4: assert property (@(posedge clk) disable iff (!rst_n)
      res_valid |-> !(res_mcast && res_bcast));

   p_flags_gated_r12: assert property (@(posedge clk) disable iff (!rst_n)
      (res_accept || res_mcast || res_bcast || res_filt_fail) |-> res_valid);

   p_flags_need_accept_r12: assert property (@(posedge clk) disable iff (!rst_n)
      (res_mcast || res_bcast || res_filt_fail) |-> res_accept);

   p_promisc_keeps_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (res_valid && $past(mode_q.promisc)) |-> (res_accept && !res_filt_fail));

   p_fail_needs_pass_r11: assert property (@(posedge clk) disable iff (!rst_n)
      res_filt_fail |-> $past(mode_q.pass_all));

endmodule

bind rx_addr_filter rx_addr_filter_chk chk_i (
   .clk           (clk),
   .rst_n         (rst_n),
   .da_valid      (da_valid),
   .res_valid     (res_valid),
   .res_accept    (res_accept),
   .res_mcast     (res_mcast),
   .res_bcast     (res_bcast),
   .res_filt_fail (res_filt_fail),
   .mode_q        (mode_q)
);

// File: tb/rx_addr_filter_tb_top.sv
module rx_addr_filter_tb_top;

   localparam logic [31:0] C_BD  = 32'h0000_0800;
   localparam logic [31:0] C_HM  = 32'h0000_2000;
   localparam logic [31:0] C_HO  = 32'h0000_8000;
   localparam logic [31:0] C_PA  = 32'h0001_0000;
   localparam logic [31:0] C_INV = 32'h0002_0000;
   localparam logic [31:0] C_PR  = 32'h0004_0000;
   localparam logic [31:0] C_PAM = 32'h0008_0000;

   // byte 0 sits in bits 7:0
   localparam logic [47:0] STA  = 48'h5544_3322_1102;
   localparam logic [47:0] UNI2 = 48'h5544_3322_1104;
   localparam logic [47:0] MC   = 48'h0100_5E00_0001;
   localparam logic [47:0] BC   = 48'hFFFF_FFFF_FFFF;

   typedef struct packed {
      logic [31:0] ctrl;
      logic [47:0] da;
      logic [1:0]  hsel;   // 0 empty table, 1 own bit only, 2 every other bit
      logic [3:0]  rq;
      logic [3:0]  exp;    // {accept, mcast, bcast, filt_fail}
   } vec_t;

   localparam int NV = 22;
   localparam vec_t VECS [NV] = '{
      '{32'h0,       STA,  2'd0, 4'd5,  4'b1000},  // R5 exact hit
      '{32'h0,       UNI2, 2'd0, 4'd5,  4'b0000},  // R5 miss
      '{C_INV,       STA,  2'd0, 4'd6,  4'b0000},  // R6
      '{C_INV,       UNI2, 2'd0, 4'd6,  4'b1000},  // R6
      '{C_HO,        STA,  2'd0, 4'd7,  4'b0000},  // R7 exact ignored
      '{C_HO,        UNI2, 2'd1, 4'd7,  4'b1000},  // R7
      '{C_HO,        UNI2, 2'd2, 4'd7,  4'b0000},  // R7 other bits only
      '{32'h0,       BC,   2'd0, 4'd8,  4'b1010},  // R8
      '{C_BD,        BC,   2'd0, 4'd8,  4'b0000},  // R8
      '{C_BD | C_PAM, BC,  2'd0, 4'd8,  4'b0000},  // R8
      '{32'h0,       MC,   2'd1, 4'd9,  4'b0000},  // R9 hash check off
      '{C_HM,        MC,   2'd1, 4'd9,  4'b1100},  // R9
      '{C_HM,        MC,   2'd2, 4'd9,  4'b0000},  // R9
      '{C_PAM,       MC,   2'd0, 4'd9,  4'b1100},  // R9
      '{C_PR,        UNI2, 2'd0, 4'd10, 4'b1000},  // R10
      '{C_PR | C_BD, BC,   2'd0, 4'd10, 4'b1010},  // R10 with R4 flag
      '{C_PA,        UNI2, 2'd0, 4'd11, 4'b1001},  // R11
      '{C_PA,        STA,  2'd0, 4'd11, 4'b1000},  // R11
      '{C_PA,        MC,   2'd0, 4'd11, 4'b1101},  // R11 with R4 flag
      '{C_PA | C_PR, MC,   2'd0, 4'd10, 4'b1100},  // R10 over R11
      '{C_HM | C_INV, MC,  2'd1, 4'd6,  4'b1100},  // R6 group untouched
      '{C_HO | C_INV, UNI2, 2'd1, 4'd6, 4'b0000}   // R6 with R7
   };

   logic        clk = 1'b0;
   logic        rst_n;
   logic        cfg_we;
   logic [2:0]  cfg_sel;
   logic [31:0] cfg_wdata;
   logic        da_valid, da_sof;
   logic [7:0]  da_byte;
   logic        res_valid, res_accept, res_mcast, res_bcast, res_filt_fail;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   always #2 clk = ~clk;

   rx_addr_filter dut_i (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
      .cfg_wdata(cfg_wdata), .da_valid(da_valid), .da_sof(da_sof),
      .da_byte(da_byte), .res_valid(res_valid), .res_accept(res_accept),
      .res_mcast(res_mcast), .res_bcast(res_bcast), .res_filt_fail(res_filt_fail)
   );

   function automatic logic [5:0] ref_idx(input logic [47:0] a);
      logic [31:0] c;
      logic        fb;
      c = 32'hFFFF_FFFF;
      for (int k = 0; k < 6; k++)
         for (int i = 0; i < 8; i++) begin
            fb = c[31] ^ a[8*k+i];
            c  = c << 1;
            if (fb) c = c ^ 32'h04C11DB7;
         end
      return c[31:26];
   endfunction

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [2:0] s, input logic [31:0] d);
      @(negedge clk);
      cfg_we = 1'b1; cfg_sel = s; cfg_wdata = d;
      @(negedge clk);
      cfg_we = 1'b0;
   endtask

   task automatic set_station(input logic [47:0] a);
      wr(3'd1, {16'h0, a[47:32]});
      wr(3'd2, a[31:0]);
   endtask

   task automatic set_table(input logic [63:0] t);
      wr(3'd3, t[63:32]);
      wr(3'd4, t[31:0]);
   endtask

   function automatic logic [3:0] outs();
      return {res_accept, res_mcast, res_bcast, res_filt_fail};
   endfunction

   // send six bytes, optional idle cycle between bytes; returns the result
   task automatic send(input logic [47:0] a, input bit gap,
                       output logic vld, output logic [3:0] got);
      for (int k = 0; k < 6; k++) begin
         @(negedge clk);
         da_valid = 1'b1; da_sof = (k == 0); da_byte = a[8*k +: 8];
         if (gap && k < 5) begin
            @(negedge clk);
            da_valid = 1'b0; da_sof = 1'b0;
         end
      end
      @(negedge clk);
      da_valid = 1'b0; da_sof = 1'b0;
      vld = res_valid;
      got = outs();
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         checks++; fails++;
         $display("FAIL watchdog: actual running expected finished");
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end

   initial begin
      logic        vld;
      logic [3:0]  got;
      logic [5:0]  ix;
      logic [47:0] a_hi, a_lo;
      bit          f_hi, f_lo;
      logic        seen;

      rst_n = 1'b0; cfg_we = 1'b0; cfg_sel = '0; cfg_wdata = '0;
      da_valid = 1'b0; da_sof = 1'b0; da_byte = '0;
      repeat (3) @(negedge clk);
      chk("R12 reset outputs", {27'h0, res_valid, outs()}, 32'h0);
      rst_n = 1'b1;

      set_station(STA);

      // ---------------- vector table ----------------
      for (int i = 0; i < NV; i++) begin
         wr(3'd0, VECS[i].ctrl);
         ix = ref_idx(VECS[i].da);
         case (VECS[i].hsel)
            2'd1:    set_table(64'h1 << ix);
            2'd2:    set_table(~(64'h1 << ix));
            default: set_table(64'h0);
         endcase
         send(VECS[i].da, 1'b0, vld, got);
         chk($sformatf("R1 vector %0d result pulse", i), {31'h0, vld}, 32'h1);
         chk($sformatf("R%0d vector %0d", VECS[i].rq, i), {28'h0, got}, {28'h0, VECS[i].exp});
         @(negedge clk);
         chk($sformatf("R12 vector %0d after pulse", i), {27'h0, res_valid, outs()}, 32'h0);
      end

      // ---------------- directed ----------------
      wr(3'd0, 32'h0);
      set_table(64'h0);

      // R1: idle cycles between bytes
      send(STA, 1'b1, vld, got);
      chk("R1 gapped frame", {27'h0, vld, got}, {27'h0, 1'b1, 4'b1000});

      // R1: bytes with no open frame ignored
      seen = 1'b0;
      for (int k = 0; k < 8; k++) begin
         @(negedge clk);
         seen |= res_valid;
         da_valid = 1'b1; da_sof = 1'b0; da_byte = STA[8*(k%6) +: 8];
      end
      @(negedge clk); seen |= res_valid; da_valid = 1'b0;
      @(negedge clk); seen |= res_valid;
      chk("R1 stray bytes ignored", {31'h0, seen}, 32'h0);

      // R1: new start flag restarts capture
      for (int k = 0; k < 3; k++) begin
         @(negedge clk);
         da_valid = 1'b1; da_sof = (k == 0); da_byte = UNI2[8*k +: 8];
      end
      send(STA, 1'b0, vld, got);
      chk("R1 restart on start flag", {27'h0, vld, got}, {27'h0, 1'b1, 4'b1000});

      // R2: station word mapping
      set_station(48'hA1B2_C3D4_E5F6);
      send(48'hA1B2_C3D4_E5F6, 1'b0, vld, got);
      chk("R2 new station accepted", {28'h0, got}, {28'h0, 4'b1000});
      send(48'hB2A1_C3D4_E5F6, 1'b0, vld, got);
      chk("R2 swapped high bytes rejected", {28'h0, got}, 32'h0);
      send(STA, 1'b0, vld, got);
      chk("R2 old station rejected", {28'h0, got}, 32'h0);

      // R2/R3: hash word halves
      f_hi = 1'b0; f_lo = 1'b0; a_hi = '0; a_lo = '0;
      for (int n = 0; n < 256; n++) begin
         logic [47:0] cand;
         cand = {40'h00_005E_0000, 8'h01} | (48'(n) << 8);
         if (ref_idx(cand) >= 6'd32 && !f_hi) begin a_hi = cand; f_hi = 1'b1; end
         if (ref_idx(cand) <  6'd32 && !f_lo) begin a_lo = cand; f_lo = 1'b1; end
      end
      chk("R3 candidates found", {30'h0, f_hi, f_lo}, 32'h3);
      wr(3'd0, C_HM);
      set_table(64'h1 << ref_idx(a_hi));
      send(a_hi, 1'b0, vld, got);
      chk("R3 high-half index hit", {28'h0, got}, {28'h0, 4'b1100});
      set_table(64'h1 << (ref_idx(a_hi) ^ 6'd32));
      send(a_hi, 1'b0, vld, got);
      chk("R2 high-half index in low word misses", {28'h0, got}, 32'h0);
      set_table(64'h1 << ref_idx(a_lo));
      send(a_lo, 1'b0, vld, got);
      chk("R3 low-half index hit", {28'h0, got}, {28'h0, 4'b1100});
      set_table(64'h1 << (ref_idx(a_lo) ^ 6'd32));
      send(a_lo, 1'b0, vld, got);
      chk("R2 low-half index in high word misses", {28'h0, got}, 32'h0);

      // R12: reset in mid-frame
      for (int k = 0; k < 3; k++) begin
         @(negedge clk);
         da_valid = 1'b1; da_sof = (k == 0); da_byte = BC[8*k +: 8];
      end
      @(negedge clk); da_valid = 1'b0; rst_n = 1'b0;
      @(negedge clk); rst_n = 1'b1;
      chk("R12 outputs after reset", {27'h0, res_valid, outs()}, 32'h0);
      seen = 1'b0;
      for (int k = 3; k < 6; k++) begin
         @(negedge clk);
         seen |= res_valid;
         da_valid = 1'b1; da_sof = 1'b0; da_byte = BC[8*k +: 8];
      end
      @(negedge clk); seen |= res_valid; da_valid = 1'b0;
      @(negedge clk); seen |= res_valid;
      chk("R1 frame tail after reset ignored", {31'h0, seen}, 32'h0);
      send(BC, 1'b0, vld, got);
      chk("R8 broadcast after reset", {27'h0, vld, got}, {27'h0, 1'b1, 4'b1010});

      done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

endmodule